// File: doc/BRIEF.md
# Two-Wire Slave Transmitter with Event Codes

This block is the slave side of a two-wire serial bus (I2C) that answers read requests aimed at its own 7-bit address and returns data bytes to the master. Both bus lines are open-drain. Each line is modelled as a drive-low enable going out and a sampled level coming in. The incoming levels pass through a synchronizer and are sampled on the system clock. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.

The host side uses a few register-style inputs and outputs. A data strobe loads the byte to be sent next. A control strobe writes the acknowledge-enable bit and the stop bit, and it can clear the event flag by writing a one to it. After each bus event the block raises the event flag and reports a byte-wide event code. While that flag is up, the block holds SCL low so the host has time to act. When the flag is down, the code reads as a fixed "nothing to report" value. A START or STOP inside an address byte, a data byte or an acknowledge slot is a bus error. The host leaves the error with a recovery write that releases both lines and sends nothing on the bus.

The FSM states are:
- IDLE: unaddressed, waiting for START.
- ADDR: shifting in the address and direction bit.
- ADDR_ACK: driving the address acknowledge.
- HOLD_TX: flag up, waiting for the next byte.
- TX: shifting a byte out.
- TX_ACK: sampling the master's acknowledge.
- HOLD_END: flag up, transfer over.
- ERR: bus error.

The transitions are:
- IDLE to ADDR on START.
- ADDR to ADDR_ACK on the SCL fall after 8 bits when the address matches and the read bit is set. ADDR to IDLE on that fall otherwise.
- ADDR_ACK to HOLD_TX on the next SCL fall.
- HOLD_TX to TX on a flag clear.
- TX to TX_ACK after the 8th SCL fall.
- TX_ACK to HOLD_TX when the master acknowledges and the byte was not marked last.
- TX_ACK to HOLD_END when the master does not acknowledge, or when it acknowledges a byte marked last.
- HOLD_END to IDLE on a flag clear.
- ADDR, ADDR_ACK, TX or TX_ACK to ERR on an illegal START or STOP.
- Any flagged state to IDLE on a recovery write.

Top module: `i2c_slave_tx`

## Requirements
- R1: While the event flag is clear, status_code reads 0xF8.
- R2: An address byte that matches own_addr, has the direction bit (last bit) set to 1 (read), and arrives while ack_en_out is 1 is acknowledged: SDA is pulled low in the acknowledge slot. After that slot's SCL fall, the flag rises and the code is 0xA8.
- R3: No acknowledge is given, the flag stays clear and the block returns to IDLE in each of these cases: the address does not match, the direction bit is 0, or ack_en_out is 0.
- R4: After the flag is cleared in HOLD_TX, the byte last loaded through data_wr is sent MSB first, one bit per SCL period.
- R5: A byte acknowledged by the master (SDA low in its acknowledge slot) gives code 0xB8 when ack_en_out was 1 at that byte's flag clear. Any number of bytes may follow within one transfer.
- R6: A byte the master does not acknowledge gives code 0xC0. After the next flag clear, the block is unaddressed and SDA is released.
- R7: If ack_en_out is 0 at a byte's flag clear and the master acknowledges that byte, the code is 0xC8. After the next flag clear, the block is unaddressed and further bytes read as 0xFF.
- R8: A START or STOP during an address byte, a data byte or an acknowledge slot raises the flag with code 0x00, and both drive-low enables go to 0.
- R9: A control write with stop=1 and flag-clear=1 while the flag is up returns the block to IDLE, clears stop_out and the flag, and puts no STOP on the bus. A new address is then accepted.
- R10: The three low bits of status_code are always 0.
- R11: While the flag is up with a non-error code, SCL is held low. In the error state, SCL is released.
- R12: In the error state, a flag-clear write with stop=0 is ignored: the flag stays up and the code stays 0x00.
- R13: After reset, the flag is clear, the code reads 0xF8, both drive-low enables are 0, and ack_en_out and stop_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| own_addr | input | ADDR_W | Slave address to match |
| data_wr | input | 1 | Load strobe for data_in |
| data_in | input | DATA_W | Next byte to transmit |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_ack_en | input | 1 | Acknowledge-enable value written |
| ctrl_stop | input | 1 | Stop/recover bit written |
| ctrl_flag_clr | input | 1 | Writing 1 clears the event flag |
| irq_flag | output | 1 | Event flag |
| status_code | output | 8 | Event code |
| ack_en_out | output | 1 | Current acknowledge-enable bit |
| stop_out | output | 1 | Current stop bit |

## Verification
The hardest situations to reach are the illegal bus conditions, because the slave itself drives SDA during most of a byte. The bench raises a STOP partway through an address byte, while the slave is not driving SDA. It raises a START in the middle of a data bit whose value is 1, so SDA is released and the master can pull it low while SCL is high. The final-byte case is reached by clearing acknowledge-enable in the same write as the flag clear, having the master acknowledge anyway, and then clocking one more byte to confirm the slave stays released.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD_TX,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD_END,
        ST_ERR
    } st_t;

    localparam logic [7:0] CODE_NONE     = 8'hF8;
    localparam logic [7:0] CODE_BUS_ERR  = 8'h00;
    localparam logic [7:0] CODE_SLA_RD   = 8'hA8;
    localparam logic [7:0] CODE_DATA_ACK = 8'hB8;
    localparam logic [7:0] CODE_DATA_NAK = 8'hC0;
    localparam logic [7:0] CODE_LAST_ACK = 8'hC8;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cst_cond.sv
module i2cst_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    assign scl_rise  = scl && !scl_p;
    assign scl_fall  = !scl && scl_p;
    assign start_det = scl && scl_p && sda_p && !sda;
    assign stop_det  = scl && scl_p && !sda_p && sda;
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2cst_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_ack_en,
    input  logic              ctrl_stop,
    input  logic              ctrl_flag_clr,
    output logic              irq_flag,
    output logic [7:0]        status_code,
    output logic              ack_en_out,
    output logic              stop_out
);
    localparam int ABITS = ADDR_W + 1;
    localparam int MAXB  = (ABITS > DATA_W) ? ABITS : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] ADDR_DONE = CNT_W'(ABITS);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2cst_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cst_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    st_t               state_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ABITS-1:0]  asr_q, asr_d;
    logic [DATA_W-1:0] tsr_q, tsr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic [7:0]        code_q, code_d;
    logic              flag_q, flag_d;
    logic              ack_en_q, ack_en_d;
    logic              stop_q, stop_d;
    logic              last_q, last_d;
    logic              mack_q, mack_d;

    logic addr_hit, active_st, bus_err, clr_req, recover;

    assign addr_hit  = (asr_q[ABITS-1:1] == own_addr) && asr_q[0] && ack_en_q;
    assign active_st = (state_q == ST_ADDR) || (state_q == ST_ADDR_ACK) ||
                       (state_q == ST_TX)   || (state_q == ST_TX_ACK);
    assign bus_err   = (start_det || stop_det) && active_st;
    assign clr_req   = ctrl_wr && ctrl_flag_clr && flag_q;
    assign recover   = clr_req && ctrl_stop;

    // next-state and register update logic
    always_comb begin
        st_d     = state_q;
        cnt_d    = cnt_q;
        asr_d    = asr_q;
        tsr_d    = tsr_q;
        data_d   = data_q;
        code_d   = code_q;
        flag_d   = flag_q;
        ack_en_d = ack_en_q;
        stop_d   = stop_q;
        last_d   = last_q;
        mack_d   = mack_q;

        if (data_wr) data_d = data_in;
        if (ctrl_wr) begin
            ack_en_d = ctrl_ack_en;
            stop_d   = ctrl_stop;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (start_det) begin
                    st_d  = ST_ADDR;
                    cnt_d = '0;
                end
            end
            ST_ADDR: begin
                if (scl_rise) begin
                    asr_d = {asr_q[ABITS-2:0], sda_s};
                    cnt_d = cnt_q + CNT_W'(1);
                end else if (scl_fall && cnt_q == ADDR_DONE) begin
                    st_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    st_d   = ST_HOLD_TX;
                    flag_d = 1'b1;
                    code_d = CODE_SLA_RD;
                end
            end
            ST_HOLD_TX: begin
                if (clr_req) begin
                    flag_d = 1'b0;
                    st_d   = ST_TX;
                    tsr_d  = data_q;
                    cnt_d  = '0;
                    last_d = !ack_en_d;
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    tsr_d = {tsr_q[DATA_W-2:0], 1'b1};
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == DATA_LAST) st_d = ST_TX_ACK;
                end
            end
            ST_TX_ACK: begin
                if (scl_rise) begin
                    mack_d = !sda_s;
                end else if (scl_fall) begin
                    flag_d = 1'b1;
                    if (!mack_q) begin
                        code_d = CODE_DATA_NAK;
                        st_d   = ST_HOLD_END;
                    end else if (last_q) begin
                        code_d = CODE_LAST_ACK;
                        st_d   = ST_HOLD_END;
                    end else begin
                        code_d = CODE_DATA_ACK;
                        st_d   = ST_HOLD_TX;
                    end
                end
            end
            ST_HOLD_END: begin
                if (clr_req) begin
                    flag_d = 1'b0;
                    st_d   = ST_IDLE;
                end
            end
            ST_ERR: begin
                // only a recovery write leaves this state
            end
            default: st_d = ST_IDLE;
        endcase

        if (recover) begin
            st_d   = ST_IDLE;
            flag_d = 1'b0;
            stop_d = 1'b0;
        end
        if (bus_err) begin
            st_d   = ST_ERR;
            flag_d = 1'b1;
            code_d = CODE_BUS_ERR;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            asr_q    <= '0;
            tsr_q    <= '1;
            data_q   <= '0;
            code_q   <= CODE_NONE;
            flag_q   <= 1'b0;
            ack_en_q <= 1'b0;
            stop_q   <= 1'b0;
            last_q   <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            state_q  <= st_d;
            cnt_q    <= cnt_d;
            asr_q    <= asr_d;
            tsr_q    <= tsr_d;
            data_q   <= data_d;
            code_q   <= code_d;
            flag_q   <= flag_d;
            ack_en_q <= ack_en_d;
            stop_q   <= stop_d;
            last_q   <= last_d;
            mack_q   <= mack_d;
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = 1'b0;
        scl_drive_low = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK:             sda_drive_low = 1'b1;
            ST_TX:                   sda_drive_low = !tsr_q[DATA_W-1];
            ST_HOLD_TX, ST_HOLD_END: scl_drive_low = 1'b1;
            default: ;
        endcase
    end

    assign irq_flag    = flag_q;
    assign status_code = flag_q ? code_q : CODE_NONE;
    assign ack_en_out  = ack_en_q;
    assign stop_out    = stop_q;

    // R10
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_code[2:0] == 3'b000);

    // R11
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && code_q != CODE_BUS_ERR) |-> scl_drive_low);

    // R8
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && code_q == CODE_BUS_ERR) |-> (!sda_drive_low && !scl_drive_low));

    // R8
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (flag_q && code_q == CODE_BUS_ERR));

    // R9
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (!flag_q && !stop_q && !sda_drive_low && !scl_drive_low));
endmodule

// File: tb/i2c_slave_tx_test.sv
module i2c_slave_tx_test;
    localparam int Q = 8;
    localparam logic [6:0] MY_ADDR = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_drive_low, sda_drive_low;
    logic scl_line, sda_line;
    logic data_wr = 1'b0, ctrl_wr = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic ctrl_ack_en = 1'b0, ctrl_stop = 1'b0, ctrl_flag_clr = 1'b0;
    logic irq_flag, ack_en_out, stop_out;
    logic [7:0] status_code;

    assign scl_line = !(m_scl_low || scl_drive_low);
    assign sda_line = !(m_sda_low || sda_drive_low);

    i2c_slave_tx uut (
        .clk(clk), .rst_n(rst_n),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(MY_ADDR),
        .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_ack_en(ctrl_ack_en), .ctrl_stop(ctrl_stop),
        .ctrl_flag_clr(ctrl_flag_clr),
        .irq_flag(irq_flag), .status_code(status_code),
        .ack_en_out(ack_en_out), .stop_out(stop_out)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model: expected flag/code, compared every clock when settled
    bit mdl_on = 0;
    logic exp_flag = 1'b0;
    logic [7:0] exp_code = 8'hF8;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mdl_on && rst_n && !done) begin
            chk("R1 model flag", irq_flag, exp_flag);
            chk("R1 model status", status_code, exp_flag ? exp_code : 8'hF8);
            chk("R11 model stretch", scl_drive_low, exp_flag && exp_code != 8'h00);
        end
    end

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(logic f, logic [7:0] c);
        exp_flag = f;
        exp_code = c;
        mdl_on = 1;
    endtask

    task automatic wait_scl_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        mdl_on = 0;
        m_sda_low = 0; m_scl_low = 0; w(Q);
        m_sda_low = 1; w(Q);
        m_scl_low = 1; w(Q);
    endtask

    task automatic bus_stop();
        mdl_on = 0;
        m_sda_low = 1; w(Q);
        m_scl_low = 0; wait_scl_high(); w(Q);
        m_sda_low = 0; w(Q);
    endtask

    task automatic send_bit(logic b);
        mdl_on = 0;
        m_sda_low = !b; w(Q);
        m_scl_low = 0; wait_scl_high(); w(Q);
        m_scl_low = 1; w(Q);
    endtask

    task automatic read_bit(output logic b);
        mdl_on = 0;
        m_sda_low = 0; w(Q);
        m_scl_low = 0; wait_scl_high(); w(Q/2);
        b = sda_line; w(Q/2);
        m_scl_low = 1; w(Q);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
    endtask

    task automatic send_addr(logic [6:0] a, logic rd, output logic ack);
        logic b;
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rd);
        read_bit(b);
        ack = !b;
    endtask

    task automatic host_data(logic [7:0] d);
        mdl_on = 0;
        data_in = d; data_wr = 1; w(1); data_wr = 0; w(1);
    endtask

    task automatic host_ctrl(logic ae, logic st, logic clr);
        mdl_on = 0;
        ctrl_ack_en = ae; ctrl_stop = st; ctrl_flag_clr = clr;
        ctrl_wr = 1; w(1); ctrl_wr = 0; ctrl_flag_clr = 0; w(4);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        w(3);
        rst_n = 1;
        w(2);
        // R13 reset state
        chk("R13 flag", irq_flag, 0);
        chk("R13 status", status_code, 8'hF8);
        chk("R13 sda drive", sda_drive_low, 0);
        chk("R13 scl drive", scl_drive_low, 0);
        chk("R13 ack_en", ack_en_out, 0);
        chk("R13 stop", stop_out, 0);
        settle(0, 8'hF8);
        w(5);

        host_ctrl(1, 0, 0);
        settle(0, 8'hF8);

        // R3 write direction
        bus_start(); send_addr(MY_ADDR, 0, ack);
        chk("R3 write dir nack", ack, 0);
        chk("R1 F8 idle", status_code, 8'hF8);
        settle(0, 8'hF8); w(5);
        bus_stop();
        // R3 other address
        bus_start(); send_addr(7'h33, 1, ack);
        chk("R3 mismatch nack", ack, 0);
        chk("R3 flag clear", irq_flag, 0);
        bus_stop();
        // R3 ack disabled
        host_ctrl(0, 0, 0);
        bus_start(); send_addr(MY_ADDR, 1, ack);
        chk("R3 ack_en off nack", ack, 0);
        chk("R3 flag clear off", irq_flag, 0);
        bus_stop();
        host_ctrl(1, 0, 0);

        // R2/R4/R5/R6 two-byte read ending in nack
        bus_start(); send_addr(MY_ADDR, 1, ack);
        chk("R2 addr ack", ack, 1);
        chk("R2 code A8", status_code, 8'hA8);
        chk("R11 stretch A8", scl_drive_low, 1);
        settle(1, 8'hA8); w(10);
        host_data(8'hA5); host_ctrl(1, 0, 1);
        settle(0, 8'hF8); w(3);
        read_byte(v);
        chk("R4 byte A5", v, 8'hA5);
        send_bit(0);
        chk("R5 code B8", status_code, 8'hB8);
        settle(1, 8'hB8); w(10);
        host_data(8'h3C); host_ctrl(1, 0, 1);
        read_byte(v);
        chk("R5 second byte", v, 8'h3C);
        send_bit(1);
        chk("R6 code C0", status_code, 8'hC0);
        settle(1, 8'hC0); w(10);
        host_ctrl(1, 0, 1);
        chk("R6 flag clear", irq_flag, 0);
        chk("R6 sda released", sda_drive_low, 0);
        settle(0, 8'hF8); w(5);
        bus_stop();

        // R7 last byte acknowledged anyway
        bus_start(); send_addr(MY_ADDR, 1, ack);
        chk("R2 addr ack 2", ack, 1);
        host_data(8'h81); host_ctrl(1, 0, 1);
        read_byte(v);
        chk("R4 byte 81", v, 8'h81);
        send_bit(0);
        chk("R5 code B8 2", status_code, 8'hB8);
        host_data(8'h7E); host_ctrl(0, 0, 1);
        read_byte(v);
        chk("R4 byte 7E", v, 8'h7E);
        send_bit(0);
        chk("R7 code C8", status_code, 8'hC8);
        settle(1, 8'hC8); w(10);
        host_ctrl(0, 0, 1);
        read_byte(v);
        chk("R7 ones after", v, 8'hFF);
        chk("R7 flag stays clear", irq_flag, 0);
        bus_stop();
        host_ctrl(1, 0, 0);

        // R8 STOP inside address byte
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_stop();
        chk("R8 addr err flag", irq_flag, 1);
        chk("R8 addr err code", status_code, 8'h00);
        chk("R8 sda released", sda_drive_low, 0);
        chk("R8 scl released", scl_drive_low, 0);
        settle(1, 8'h00); w(10);
        // R12 clear without stop ignored
        host_ctrl(1, 0, 1);
        chk("R12 flag kept", irq_flag, 1);
        chk("R12 code kept", status_code, 8'h00);
        // R9 recovery
        host_ctrl(1, 1, 1);
        chk("R9 flag clear", irq_flag, 0);
        chk("R9 stop cleared", stop_out, 0);
        chk("R9 ack_en kept", ack_en_out, 1);
        chk("R9 status F8", status_code, 8'hF8);
        chk("R9 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R9 no STOP driven", sda_line, 1);
        settle(0, 8'hF8); w(5);
        bus_start(); send_addr(MY_ADDR, 1, ack);
        chk("R9 new addr ack", ack, 1);
        chk("R9 A8 after recover", status_code, 8'hA8);

        // R8 START inside a data bit of value 1
        host_data(8'hF0); host_ctrl(1, 0, 1);
        mdl_on = 0;
        m_sda_low = 0; w(Q);
        m_scl_low = 0; wait_scl_high(); w(Q);
        m_sda_low = 1; w(Q);
        chk("R8 data err code", status_code, 8'h00);
        chk("R8 data err flag", irq_flag, 1);
        chk("R8 data err sda", sda_drive_low, 0);
        chk("R8 data err scl", scl_drive_low, 0);
        host_ctrl(1, 1, 1);
        chk("R9 second recover", status_code, 8'hF8);
        m_sda_low = 0; w(Q);
        chk("R9 idle after stop", irq_flag, 0);
        settle(0, 8'hF8); w(20);

        summary();
        $finish;
    end
endmodule